// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Colour Matrix

This block turns a stream of 10-bit-per-component pixels into another colour space with a programmable 3x3 matrix. Its usual job is to convert RGB to limited-range YCbCr. A pixel arrives with a valid flag on any cycle. Each component first has a signed input offset removed. The three corrected components are then multiplied by signed fixed-point gains with 10 fractional bits. Each row's products are summed, rounded, scaled down and moved by a signed output offset. The result is limited to the 10-bit range.

Software programs the matrix through a simple write port. Writes land in a staging copy. That copy becomes live only on a frame-start pulse, so a frame is never converted with a mix of old and new settings. When the enable bit is clear, pixels pass through unchanged with the same three-cycle latency and the same valid timing.

Top module: `csc_matrix`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock edges. `out_valid` and `out_pix` are 0 during and right after reset.
- R2: Pixel components are packed with component 0 in bits 29:20, component 1 in bits 19:10 and component 2 in bits 9:0, and output row r uses the same slot as input component r. With conversion enabled, output r = clamp(((sum over c of K[r][c]*(x[c]-P[c])) + 512) >>> (10+S) + Q[r]), where `>>>` is an arithmetic shift.
- R3: Each output component is saturated to 0 when the offset result is negative, and to 1023 when it exceeds 1023.
- R4: With the enable bit clear, `out_pix` equals the `in_pix` sampled three edges earlier.
- R5: Register writes change nothing until a `frame_start` pulse. On that edge all staged values become active together. If a write coincides with the pulse, the write waits for the next pulse.
- R6: The enable bit is bit 0 of address 0. Input offsets P are 12-bit two's complement: P0 is in bits 27:16 and P1 in bits 11:0 of address 1, and P2 is in bits 11:0 of address 2. Output offsets Q use the same layout at addresses 8 and 9.
- R7: Gains K are 13-bit two's complement, two per word: bits 28:16 hold the earlier gain and bits 12:0 the later one. They are stored in row-major order starting with K00 at address 3, so address 7 carries only K22, in bits 28:16.
- R8: The extra right shift S is bits 18:16 of address 10. All other bits of that word are ignored.
- R9: After reset the block is enabled with P=0, Q=(64,512,512) and the limited-range gain rows (186,627,63), (-103,-345,448), (448,-407,-41), with S=0. Black therefore maps to (64,512,512) and full white to (939,512,512).
- R10: Writes to addresses 11 to 15 have no effect on the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Pulse that moves staged settings into the active set |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 30 | Input pixel, three 10-bit components |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 30 | Converted or passed-through pixel |

## Verification
A corrupted active setting shows up at the ports as soon as the next pixel has crossed the three pipeline stages. A bad gain or offset skews every converted pixel. A wrong shift or clamp shows first on saturated or high-gain inputs. A staging fault shows on the first pixel after a write that was not followed by a frame pulse, because the outputs change when they should not. A misaligned valid pipeline makes `out_valid` differ from the input valid three cycles later on any irregular valid pattern.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int DW     = 10;            // bits per component
  localparam int NC     = 3;             // components per pixel
  localparam int OFW    = 12;            // offset field width
  localparam int CFW    = 13;            // gain field width
  localparam int FRAC   = 10;            // fractional bits in a gain
  localparam int SHW    = 3;             // extra shift field width
  localparam int RAW    = 4;             // register address width
  localparam int DFW    = OFW + 1;       // width after offset removal
  localparam int SW     = DFW + CFW + 2; // row sum width
  localparam int XW     = SW + 1;        // post-processing width
  localparam int PIXW   = NC * DW;

  localparam logic [RAW-1:0] A_CTRL   = 4'd0;
  localparam logic [RAW-1:0] A_PRE01  = 4'd1;
  localparam logic [RAW-1:0] A_PRE2   = 4'd2;
  localparam logic [RAW-1:0] A_K0     = 4'd3;
  localparam logic [RAW-1:0] A_K1     = 4'd4;
  localparam logic [RAW-1:0] A_K2     = 4'd5;
  localparam logic [RAW-1:0] A_K3     = 4'd6;
  localparam logic [RAW-1:0] A_K4     = 4'd7;
  localparam logic [RAW-1:0] A_POST01 = 4'd8;
  localparam logic [RAW-1:0] A_POST2  = 4'd9;
  localparam logic [RAW-1:0] A_MODE   = 4'd10;

  typedef struct packed {
    logic                        en;
    logic [SHW-1:0]              shift;
    logic [NC-1:0][OFW-1:0]      pre;
    logic [NC-1:0][OFW-1:0]      post;
    logic [NC*NC-1:0][CFW-1:0]   coef;
  } cfg_t;

  function automatic cfg_t cfg_default();
    cfg_t c;
    c.en      = 1'b1;
    c.shift   = '0;
    c.pre     = '0;
    c.post[0] = OFW'(64);
    c.post[1] = OFW'(512);
    c.post[2] = OFW'(512);
    c.coef[0] = CFW'(186);
    c.coef[1] = CFW'(627);
    c.coef[2] = CFW'(63);
    c.coef[3] = CFW'(-103);
    c.coef[4] = CFW'(-345);
    c.coef[5] = CFW'(448);
    c.coef[6] = CFW'(448);
    c.coef[7] = CFW'(-407);
    c.coef[8] = CFW'(-41);
    return c;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           frame_start,
  output cfg_t           active
);
  cfg_t staged;
  logic unused_bits;
  assign unused_bits = ^{wr_data[31:29], wr_data[15:13]};

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= cfg_default();
      active <= cfg_default();
    end else begin
      if (frame_start) active <= staged;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:   staged.en <= wr_data[0];
          A_PRE01:  begin
                      staged.pre[0] <= wr_data[16 +: OFW];
                      staged.pre[1] <= wr_data[0 +: OFW];
                    end
          A_PRE2:   staged.pre[2] <= wr_data[0 +: OFW];
          A_K0:     begin
                      staged.coef[0] <= wr_data[16 +: CFW];
                      staged.coef[1] <= wr_data[0 +: CFW];
                    end
          A_K1:     begin
                      staged.coef[2] <= wr_data[16 +: CFW];
                      staged.coef[3] <= wr_data[0 +: CFW];
                    end
          A_K2:     begin
                      staged.coef[4] <= wr_data[16 +: CFW];
                      staged.coef[5] <= wr_data[0 +: CFW];
                    end
          A_K3:     begin
                      staged.coef[6] <= wr_data[16 +: CFW];
                      staged.coef[7] <= wr_data[0 +: CFW];
                    end
          A_K4:     staged.coef[8] <= wr_data[16 +: CFW];
          A_POST01: begin
                      staged.post[0] <= wr_data[16 +: OFW];
                      staged.post[1] <= wr_data[0 +: OFW];
                    end
          A_POST2:  staged.post[2] <= wr_data[0 +: OFW];
          A_MODE:   staged.shift <= wr_data[16 +: SHW];
          default:  ;
        endcase
      end
    end
  end

  // Active settings move only on a frame pulse (R5)
  assert_hold_until_frame_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(active));

  assert_frame_load_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> active == $past(staged));

  // Enable bit lands in the staging copy (R6)
  assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CTRL) |=> staged.en == $past(wr_data[0]));

  // Extra shift comes from bits 18:16 of the mode word (R8)
  assert_shift_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MODE) |=> staged.shift == $past(wr_data[18:16]));
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NC-1:0][DFW-1:0] diff,
  input  logic [NC-1:0][CFW-1:0] coef,
  input  logic [OFW-1:0]         post,
  input  logic [SHW-1:0]         shift,
  output logic [DW-1:0]          y,
  output logic                   sat_lo,
  output logic                   sat_hi
);
  localparam logic signed [XW-1:0] YMAX = XW'((1 << DW) - 1);
  localparam logic signed [XW-1:0] HALF = XW'(1 << (FRAC - 1));

  logic signed [SW-1:0] sum, acc_q;
  logic signed [XW-1:0] rnd, shf, pos;

  always_comb begin
    sum = '0;
    for (int c = 0; c < NC; c++) begin
      sum = sum + SW'($signed(diff[c])) * SW'($signed(coef[c]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum;
  end

  always_comb begin
    rnd    = XW'(acc_q) + HALF;
    shf    = rnd >>> (FRAC + int'(shift));
    pos    = shf + XW'($signed(post));
    sat_lo = pos < 0;
    sat_hi = pos > YMAX;
    if (sat_lo)      y = '0;
    else if (sat_hi) y = '1;
    else             y = pos[DW-1:0];
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            frame_start,
  input  logic            in_valid,
  input  logic [29:0]     in_pix,
  output logic            out_valid,
  output logic [29:0]     out_pix
);
  cfg_t cfg;

  csc_cfg_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .frame_start (frame_start),
    .active      (cfg)
  );

  // Stage 1: remove input offsets
  logic                   s1_v, s1_en;
  logic [PIXW-1:0]        s1_pix;
  logic [NC-1:0][DFW-1:0] s1_diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_en   <= 1'b0;
      s1_pix  <= '0;
      s1_diff <= '0;
    end else begin
      s1_v   <= in_valid;
      s1_en  <= cfg.en;
      s1_pix <= in_pix;
      for (int c = 0; c < NC; c++) begin
        s1_diff[c] <= DFW'({{(DFW-DW){1'b0}}, in_pix[(NC-1-c)*DW +: DW]})
                    - DFW'($signed(cfg.pre[c]));
      end
    end
  end

  // Stage 2: row sums are registered inside each row
  logic            s2_v, s2_en;
  logic [PIXW-1:0] s2_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v   <= 1'b0;
      s2_en  <= 1'b0;
      s2_pix <= '0;
    end else begin
      s2_v   <= s1_v;
      s2_en  <= s1_en;
      s2_pix <= s1_pix;
    end
  end

  logic [NC-1:0][DW-1:0] row_y;
  logic [NC-1:0]         row_lo, row_hi;

  for (genvar r = 0; r < NC; r++) begin : g_row
    csc_row u_row (
      .clk    (clk),
      .rst    (rst),
      .diff   (s1_diff),
      .coef   (cfg.coef[r*NC +: NC]),
      .post   (cfg.post[r]),
      .shift  (cfg.shift),
      .y      (row_y[r]),
      .sat_lo (row_lo[r]),
      .sat_hi (row_hi[r])
    );

    // Saturation reaches the port one edge later (R3)
    assert_clamp_lo_R3: assert property (@(posedge clk) disable iff (rst)
      (s2_v && s2_en && row_lo[r]) |=> out_pix[(NC-1-r)*DW +: DW] == '0);
    assert_clamp_hi_R3: assert property (@(posedge clk) disable iff (rst)
      (s2_v && s2_en && row_hi[r]) |=> out_pix[(NC-1-r)*DW +: DW] == '1);
  end

  // Stage 3: rounding, shift, output offset, clamp, bypass select
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s2_v;
      for (int r = 0; r < NC; r++) begin
        out_pix[(NC-1-r)*DW +: DW] <= s2_en ? row_y[r]
                                            : s2_pix[(NC-1-r)*DW +: DW];
      end
    end
  end

  // Edges since reset, so the delayed checks never look into reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> out_valid == $past(in_valid, 3));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(in_valid, 3) && !$past(cfg.en, 3))
      |-> out_pix == $past(in_pix, 3));
endmodule

// File: tb/csc_matrix_test.sv
module csc_matrix_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [29:0] in_pix = '0;
  logic        out_valid;
  logic [29:0] out_pix;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_matrix uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // Behavioural model state: staged (s_) and active (a_) settings
  int s_en, s_sh, a_en, a_sh;
  int s_pre[3], s_post[3], s_k[9];
  int a_pre[3], a_post[3], a_k[9];
  bit          hv[3];
  logic [29:0] hp[3];

  function automatic int sx(input int v, input int w);
    int m;
    m = v & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  function automatic logic [29:0] model(input logic [29:0] p);
    logic [29:0] o;
    if (a_en == 0) return p;
    for (int r = 0; r < 3; r++) begin
      int acc, v;
      acc = 0;
      for (int c = 0; c < 3; c++)
        acc += a_k[3*r+c] * (int'(p[(2-c)*10 +: 10]) - a_pre[c]);
      v = ((acc + 512) >>> (10 + a_sh)) + a_post[r];
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      o[(2-r)*10 +: 10] = 10'(v);
    end
    return o;
  endfunction

  task automatic model_reset();
    int dk[9] = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
    s_en = 1; s_sh = 0;
    for (int i = 0; i < 3; i++) begin s_pre[i] = 0; end
    s_post[0] = 64; s_post[1] = 512; s_post[2] = 512;
    for (int i = 0; i < 9; i++) s_k[i] = dk[i];
    a_en = s_en; a_sh = s_sh; a_pre = s_pre; a_post = s_post; a_k = s_k;
    for (int i = 0; i < 3; i++) begin hv[i] = 0; hp[i] = '0; end
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    case (a)
      0:  s_en = int'(d[0]);
      1:  begin s_pre[0] = sx(int'(d[27:16]), 12); s_pre[1] = sx(int'(d[11:0]), 12); end
      2:  s_pre[2] = sx(int'(d[11:0]), 12);
      3, 4, 5, 6: begin
            s_k[2*(a-3)]   = sx(int'(d[28:16]), 13);
            s_k[2*(a-3)+1] = sx(int'(d[12:0]), 13);
          end
      7:  s_k[8] = sx(int'(d[28:16]), 13);
      8:  begin s_post[0] = sx(int'(d[27:16]), 12); s_post[1] = sx(int'(d[11:0]), 12); end
      9:  s_post[2] = sx(int'(d[11:0]), 12);
      10: s_sh = int'(d[18:16]);
      default: ;
    endcase
  endtask

  task automatic fail(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // One clock: drive, model the edge, compare at the following negedge
  task automatic cyc(input bit v, input logic [29:0] p, input bit we,
                     input logic [3:0] a, input logic [31:0] d, input bit fs,
                     input string tag);
    logic [29:0] e;
    in_valid = v; in_pix = p; wr_en = we; wr_addr = a; wr_data = d; frame_start = fs;
    e = model(p);
    @(posedge clk);
    if (fs) begin
      a_en = s_en; a_sh = s_sh; a_pre = s_pre; a_post = s_post; a_k = s_k;
    end
    if (we) model_write(int'(a), d);
    hv[2] = hv[1]; hp[2] = hp[1];
    hv[1] = hv[0]; hp[1] = hp[0];
    hv[0] = v;     hp[0] = e;
    @(negedge clk);
    n_chk++;
    if (out_valid !== hv[2]) fail(tag, "valid", 32'(out_valid), 32'(hv[2]));
    if (hv[2]) begin
      n_chk++;
      if (out_pix !== hp[2]) fail(tag, "pixel", 32'(out_pix), 32'(hp[2]));
    end
  endtask

  task automatic px(input logic [29:0] p, input string tag);
    cyc(1'b1, p, 1'b0, 4'd0, 32'd0, 1'b0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 4'd0, 32'd0, 1'b0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(1'b0, '0, 1'b1, a, d, 1'b0, tag);
  endtask
  task automatic frame(input string tag);
    idle(3, tag);
    cyc(1'b0, '0, 1'b0, 4'd0, 32'd0, 1'b1, tag);
  endtask
  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [29:0] p;
      p = 30'($urandom());
      cyc(1'($urandom() % 4 != 0), p, 1'b0, 4'd0, 32'd0, 1'b0, tag);
    end
  endtask
  task automatic direct(input logic [29:0] exp, input string tag);
    n_chk++;
    if (out_pix !== exp) fail(tag, "direct", 32'(out_pix), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail("watchdog", "timeout", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_pix !== '0)
      fail("R1", "reset", {1'b0, out_valid, out_pix}, 32'd0);
    rst = 1'b0;

    // R9: defaults, black and white given directly
    px(30'd0, "R9");
    idle(2, "R9");
    direct({10'd64, 10'd512, 10'd512}, "R9");
    px({10'd1023, 10'd1023, 10'd1023}, "R9");
    idle(2, "R9");
    direct({10'd939, 10'd512, 10'd512}, "R9");
    // R2: primaries and random pixels under the default matrix
    px({10'd1023, 10'd0, 10'd0}, "R2");
    px({10'd0, 10'd1023, 10'd0}, "R2");
    px({10'd0, 10'd0, 10'd1023}, "R2");
    burst(60, "R2");

    // R5: staged identity matrix has no effect before the frame pulse
    wr(4'd3, {3'd0, 13'd1024, 3'd0, 13'd0}, "R5");
    wr(4'd4, 32'd0, "R5");
    wr(4'd5, {3'd0, 13'd1024, 3'd0, 13'd0}, "R5");
    wr(4'd6, 32'd0, "R5");
    wr(4'd7, {3'd0, 13'd1024, 16'd0}, "R5");
    wr(4'd8, 32'd0, "R5");
    wr(4'd9, 32'd0, "R5");
    burst(20, "R5");
    frame("R5");
    px({10'd5, 10'd600, 10'd1000}, "R5");
    idle(2, "R5");
    direct({10'd5, 10'd600, 10'd1000}, "R5");
    burst(20, "R5");

    // R6, R7: offsets and mixed-sign gains
    wr(4'd1, {4'd0, 12'd100, 4'd0, 12'hFCE}, "R6");
    wr(4'd2, 32'd7, "R6");
    wr(4'd8, {4'd0, 12'hFF0, 4'd0, 12'd300}, "R6");
    wr(4'd9, 32'd20, "R6");
    wr(4'd3, {3'd0, 13'd700, 3'd0, 13'h1F00}, "R7");
    wr(4'd4, {3'd0, 13'd50, 3'd0, 13'h1E00}, "R7");
    wr(4'd5, {3'd0, 13'd900, 3'd0, 13'd10}, "R7");
    wr(4'd6, {3'd0, 13'h1FF0, 3'd0, 13'd333}, "R7");
    wr(4'd7, {3'd7, 13'd512, 16'hFFFF}, "R7");
    frame("R6");
    px(30'd0, "R6");
    px({10'd1023, 10'd1023, 10'd1023}, "R7");
    burst(60, "R7");

    // R8: extra shift with junk in the other bits
    wr(4'd10, 32'hC005_ABCD | (32'd2 << 16), "R8");
    frame("R8");
    burst(40, "R8");

    // R3: large gains force both saturation limits
    wr(4'd3, {3'd0, 13'd4095, 3'd0, 13'd4095}, "R3");
    wr(4'd4, {3'd0, 13'd4095, 3'd0, 13'h1001}, "R3");
    wr(4'd5, {3'd0, 13'h1001, 3'd0, 13'h1001}, "R3");
    wr(4'd6, {3'd0, 13'd2000, 3'd0, 13'h1800}, "R3");
    wr(4'd10, 32'd0, "R3");
    wr(4'd1, 32'd0, "R3");
    wr(4'd2, 32'd0, "R3");
    frame("R3");
    px({10'd1023, 10'd1023, 10'd1023}, "R3");
    px({10'd0, 10'd1023, 10'd0}, "R3");
    px(30'd0, "R3");
    burst(40, "R3");

    // R10: unmapped addresses leave the conversion unchanged
    for (int a = 11; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF, "R10");
    frame("R10");
    burst(40, "R10");

    // R4: disabled, pixels pass unchanged with the same latency
    wr(4'd0, 32'hFFFF_FFFE, "R4");
    frame("R4");
    px({10'd17, 10'd1023, 10'd0}, "R4");
    idle(2, "R4");
    direct({10'd17, 10'd1023, 10'd0}, "R4");
    burst(40, "R4");

    // R1: valid timing across an irregular pattern after re-enabling
    wr(4'd0, 32'd1, "R1");
    frame("R1");
    burst(80, "R1");
    idle(4, "R1");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule